// File: doc/BRIEF.md
# Memory Fault Capture and Trap Dispatch Unit

This unit sits beside a processor pipeline. It receives one fault event at a time. In the following cycle it sends the pipeline to the handler for that event, and in that same cycle it records the fault state that the handler will read. Each event carries a kind code, the program counter of the faulting instruction, the data virtual address, the instruction word, access flags, three request qualifiers and a trap-versus-fault indicator. The qualifiers mark page-table-entry loads, prefetches and misspeculated accesses.

The handler address is the handler base register plus a fixed offset chosen by the fault kind. The unit keeps a saved exception address, which is advanced past the faulting instruction for trap-class events. Data-side faults record the faulting address, a status word and a formatted page-table-entry address. Instruction-side faults record a tag and a formatted address. A formatted address is a page-table base register ORed with the virtual page number shifted left by three; pages are 8 KiB. Data-side capture is skipped for page-table-entry loads, prefetches and misspeculated accesses. Software loads the three base registers through a small register port, and every register can be read back through the same port.

Top module: `ftrap_top`

## Requirements
- R1: `faultKind` encoding: 0 reset, 1 interrupt, 2 machine check, 3 misalignment, 4 single data miss, 5 double data miss, 6 data page fault, 7 data access violation, 8 instruction miss, 9 instruction access violation, 10 illegal opcode, 11 arithmetic, 12 integer overflow, 13 float disabled, 14 privileged call. `newPc` equals the handler base plus the offset for the kind. The offsets are 0x0001, 0x0101, 0x0401, 0x0301, 0x0201, 0x0281, 0x0381, 0x0381, 0x0181, 0x0081, 0x0481, 0x0501, 0x0501, 0x0581 and 0x2001, in that kind order. `newPc` changes only when `redirect` is high.
- R2: On an accepted fault, the exception address (register 0) takes `faultPc` when the kind is neither arithmetic nor integer overflow, or when `faultPc[1:0]` is 0. Otherwise it keeps its old value.
- R3: When `isTrap` is high, the value from R2 is stored plus 4.
- R4: Kinds 3 to 7 are data faults. For these, the virtual-address register (register 1) takes `faultVa` only when `reqPteLoad`, `reqPrefetch` and `reqMisspec` are all low. Registers 2 and 3 follow the same rule.
- R5: The status register (register 2) holds `instrWord[31:26]` at bits 16:11 and `instrWord[25:21]` at bits 10:6. Bit 0 is `accFlags[0]` (write), bit 1 is set for kind 7, bit 2 is `accFlags[1]` (fault on read), bit 3 is `accFlags[2]` (fault on write) and bit 4 is set for kind 5. All other bits are 0.
- R6: The data formatted address (register 3) is the data table base (register 7) ORed with `faultVa[42:13]` shifted left by 3.
- R7: Kinds 8 and 9 are instruction faults. For these, when `reqMisspec` is low, the tag (register 5) takes `faultPc`. The instruction formatted address (register 4) takes the instruction table base (register 8) ORed with `faultPc[42:13]` shifted left by 3.
- R8: `redirect` is a one-cycle pulse in the cycle after a fault is accepted. All captured registers show their new values in that cycle.
- R9: `faultReady` is low while `redirect` is high. A fault offered then is not accepted and must be held until the next cycle.
- R10: Register writes take effect only at addresses 6 (handler base), 7 (data table base) and 8 (instruction table base). Writes to other addresses are ignored. Addresses 9 to 15 read as 0. A fault accepted on the same edge as a base write uses the old base.
- R11: After reset, every register reads 0, `redirect` is low, `faultReady` is high and `newPc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | A fault event is offered |
| faultKind | input | 4 | Fault kind code (R1) |
| faultPc | input | 64 | PC of the faulting instruction |
| faultVa | input | 64 | Data virtual address |
| instrWord | input | 32 | Faulting instruction word |
| accFlags | input | 3 | {fault on write, fault on read, write} |
| reqPteLoad | input | 1 | Access is a page-table-entry load |
| reqPrefetch | input | 1 | Access is a prefetch |
| reqMisspec | input | 1 | Access is misspeculated |
| isTrap | input | 1 | Event is trap-class (skip instruction) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data for `regAddr` (combinational) |
| faultReady | output | 1 | Unit can accept a fault this cycle |
| redirect | output | 1 | One-cycle redirect strobe |
| newPc | output | 64 | Handler entry PC |

## Verification
The hardest case to reach is a fault offered during the redirect cycle, while a base register is rewritten and capture is suppressed. There the stored state must stay exactly as it was, and that is visible only through the readback port. The stimulus keeps `faultValid` high for long runs so that held-off offers happen often. It sets the qualifiers at random and rewrites the bases in the middle of the run. It changes `regAddr` every cycle, so each register is compared against the model within a few cycles of every update and every skipped update.

// File: rtl/ftrap_pkg.sv
package ftrap_pkg;

  typedef enum logic [3:0] {
    K_RESET  = 4'd0,
    K_INTR   = 4'd1,
    K_MCHK   = 4'd2,
    K_ALIGN  = 4'd3,
    K_DMISS1 = 4'd4,
    K_DMISS2 = 4'd5,
    K_DPAGE  = 4'd6,
    K_DACV   = 4'd7,
    K_IMISS  = 4'd8,
    K_IACV   = 4'd9,
    K_OPDEC  = 4'd10,
    K_ARITH  = 4'd11,
    K_OVFL   = 4'd12,
    K_FEN    = 4'd13,
    K_PAL    = 4'd14,
    K_NONE   = 4'd15
  } faultKind_e;

  typedef struct packed {
    logic accept;
    logic loadExcPc;
    logic skipInstr;
    logic latchData;
    logic latchInst;
  } ctrlStrobe_t;

  localparam logic [3:0] RA_EXC   = 4'd0;
  localparam logic [3:0] RA_VA    = 4'd1;
  localparam logic [3:0] RA_MSTAT = 4'd2;
  localparam logic [3:0] RA_DFORM = 4'd3;
  localparam logic [3:0] RA_IFORM = 4'd4;
  localparam logic [3:0] RA_ITAG  = 4'd5;
  localparam logic [3:0] RA_HBASE = 4'd6;
  localparam logic [3:0] RA_DPTB  = 4'd7;
  localparam logic [3:0] RA_IPTB  = 4'd8;

  function automatic logic [15:0] vecOffset(faultKind_e k);
    case (k)
      K_RESET:         return 16'h0001;
      K_INTR:          return 16'h0101;
      K_MCHK:          return 16'h0401;
      K_ALIGN:         return 16'h0301;
      K_DMISS1:        return 16'h0201;
      K_DMISS2:        return 16'h0281;
      K_DPAGE, K_DACV: return 16'h0381;
      K_IMISS:         return 16'h0181;
      K_IACV:          return 16'h0081;
      K_OPDEC:         return 16'h0481;
      K_ARITH, K_OVFL: return 16'h0501;
      K_FEN:           return 16'h0581;
      K_PAL:           return 16'h2001;
      default:         return 16'h0000;
    endcase
  endfunction

  function automatic logic isDataKind(faultKind_e k);
    return (k == K_ALIGN) || (k == K_DMISS1) || (k == K_DMISS2) ||
           (k == K_DPAGE) || (k == K_DACV);
  endfunction

  function automatic logic isInstKind(faultKind_e k);
    return (k == K_IMISS) || (k == K_IACV);
  endfunction

  function automatic logic needsRestart(faultKind_e k);
    return !((k == K_ARITH) || (k == K_OVFL));
  endfunction

endpackage

// File: rtl/ftrap_form.sv
module ftrap_form #(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13
) (
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] virtAddr,
  output logic [ADDR_W-1:0] formAddr
);
  localparam int VPN_W = VA_BITS - PAGE_BITS;
  localparam int PAD_W = ADDR_W - VPN_W - 3;

  logic [VPN_W-1:0] vpn;
  logic unusedAddrBits;

  assign vpn            = virtAddr[VA_BITS-1:PAGE_BITS];
  assign unusedAddrBits = ^{virtAddr[ADDR_W-1:VA_BITS], virtAddr[PAGE_BITS-1:0]};
  assign formAddr       = tableBase | {{PAD_W{1'b0}}, vpn, 3'b000};
endmodule

// File: rtl/ftrap_ctrl.sv
module ftrap_ctrl
  import ftrap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        faultValid,
  input  logic [3:0]  faultKind,
  input  logic        isTrap,
  input  logic        reqPteLoad,
  input  logic        reqPrefetch,
  input  logic        reqMisspec,
  input  logic [1:0]  pcLow,
  output ctrlStrobe_t strobe,
  output logic        redirect,
  output logic        faultReady
);
  faultKind_e kind;
  logic redirectQ;
  logic acceptNow;
  logic dataQuiet;

  assign kind       = faultKind_e'(faultKind);
  assign faultReady = !redirectQ;
  assign redirect   = redirectQ;
  assign acceptNow  = faultValid && !redirectQ;
  assign dataQuiet  = reqPteLoad || reqPrefetch || reqMisspec;

  always_comb begin
    strobe.accept    = acceptNow;
    strobe.loadExcPc = acceptNow && (needsRestart(kind) || (pcLow == 2'b00));
    strobe.skipInstr = acceptNow && isTrap;
    strobe.latchData = acceptNow && isDataKind(kind) && !dataQuiet;
    strobe.latchInst = acceptNow && isInstKind(kind) && !reqMisspec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) redirectQ <= 1'b0;
    else       redirectQ <= acceptNow;
  end
endmodule

// File: rtl/ftrap_dp.sv
module ftrap_dp
  import ftrap_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int INSTR_W   = 32,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int RA_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        faultKind,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic [ADDR_W-1:0] faultVa,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [2:0]        accFlags,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic [ADDR_W-1:0] newPc
);
  localparam int MSTAT_W = 17;
  localparam int NFORM   = 2;

  faultKind_e kind;
  logic [ADDR_W-1:0] excQ, vaQ, mstatQ, dformQ, iformQ, itagQ;
  logic [ADDR_W-1:0] hbaseQ, dptbQ, iptbQ, newPcQ;
  logic [ADDR_W-1:0] excBase, excNext, mstatNext;
  logic [ADDR_W-1:0] formBase [NFORM];
  logic [ADDR_W-1:0] formSrc  [NFORM];
  logic [ADDR_W-1:0] formOut  [NFORM];
  logic [5:0] opField;
  logic [4:0] raField;
  logic [5:0] accBits;
  logic unusedInstr;

  assign kind        = faultKind_e'(faultKind);
  assign opField     = instrWord[INSTR_W-1 -: 6];
  assign raField     = instrWord[INSTR_W-7 -: 5];
  assign unusedInstr = ^instrWord[INSTR_W-12:0];

  assign accBits   = {1'b0, kind == K_DMISS2, accFlags[2], accFlags[1],
                      kind == K_DACV, accFlags[0]};
  assign mstatNext = {{(ADDR_W-MSTAT_W){1'b0}}, opField, raField, accBits};

  assign excBase = strobe.loadExcPc ? faultPc : excQ;
  assign excNext = strobe.skipInstr ? excBase + ADDR_W'(4) : excBase;

  assign formBase[0] = dptbQ;
  assign formSrc[0]  = faultVa;
  assign formBase[1] = iptbQ;
  assign formSrc[1]  = faultPc;

  for (genvar g = 0; g < NFORM; g++) begin : g_form
    ftrap_form #(
      .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .PAGE_BITS(PAGE_BITS)
    ) form_i (
      .tableBase(formBase[g]),
      .virtAddr (formSrc[g]),
      .formAddr (formOut[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excQ   <= '0; vaQ   <= '0; mstatQ <= '0; dformQ <= '0;
      iformQ <= '0; itagQ <= '0; hbaseQ <= '0; dptbQ  <= '0;
      iptbQ  <= '0; newPcQ <= '0;
    end else begin
      if (strobe.accept) begin
        excQ   <= excNext;
        newPcQ <= hbaseQ + {{(ADDR_W-16){1'b0}}, vecOffset(kind)};
      end
      if (strobe.latchData) begin
        vaQ    <= faultVa;
        mstatQ <= mstatNext;
        dformQ <= formOut[0];
      end
      if (strobe.latchInst) begin
        itagQ  <= faultPc;
        iformQ <= formOut[1];
      end
      if (regWrEn) begin
        case (regAddr)
          RA_HBASE: hbaseQ <= regWrData;
          RA_DPTB:  dptbQ  <= regWrData;
          RA_IPTB:  iptbQ  <= regWrData;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      RA_EXC:   regRdData = excQ;
      RA_VA:    regRdData = vaQ;
      RA_MSTAT: regRdData = mstatQ;
      RA_DFORM: regRdData = dformQ;
      RA_IFORM: regRdData = iformQ;
      RA_ITAG:  regRdData = itagQ;
      RA_HBASE: regRdData = hbaseQ;
      RA_DPTB:  regRdData = dptbQ;
      RA_IPTB:  regRdData = iptbQ;
      default:  regRdData = '0;
    endcase
  end

  assign newPc = newPcQ;
endmodule

// File: rtl/ftrap_top.sv
module ftrap_top
  import ftrap_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int INSTR_W   = 32,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int RA_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               faultValid,
  input  logic [3:0]         faultKind,
  input  logic [ADDR_W-1:0]  faultPc,
  input  logic [ADDR_W-1:0]  faultVa,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [2:0]         accFlags,
  input  logic               reqPteLoad,
  input  logic               reqPrefetch,
  input  logic               reqMisspec,
  input  logic               isTrap,
  input  logic               regWrEn,
  input  logic [RA_W-1:0]    regAddr,
  input  logic [ADDR_W-1:0]  regWrData,
  output logic [ADDR_W-1:0]  regRdData,
  output logic               faultReady,
  output logic               redirect,
  output logic [ADDR_W-1:0]  newPc
);
  ctrlStrobe_t strobe;

  ftrap_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .faultValid (faultValid),
    .faultKind  (faultKind),
    .isTrap     (isTrap),
    .reqPteLoad (reqPteLoad),
    .reqPrefetch(reqPrefetch),
    .reqMisspec (reqMisspec),
    .pcLow      (faultPc[1:0]),
    .strobe     (strobe),
    .redirect   (redirect),
    .faultReady (faultReady)
  );

  ftrap_dp #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .VA_BITS(VA_BITS),
    .PAGE_BITS(PAGE_BITS), .RA_W(RA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .faultKind(faultKind),
    .faultPc  (faultPc),
    .faultVa  (faultVa),
    .instrWord(instrWord),
    .accFlags (accFlags),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .newPc    (newPc)
  );
endmodule

// File: rtl/ftrap_chk.sv
module ftrap_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic              faultReady,
  input logic              redirect,
  input logic [ADDR_W-1:0] newPc
);
  // R8: redirect lasts a single cycle
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  // R8: an accepted offer yields redirect on the next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultReady) |=> redirect);

  // R8: redirect only follows an offer
  p_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(faultValid));

  // R9: no acceptance during redirect
  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> !faultReady);

  // R1: handler PC moves only with a redirect
  p_newpc_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(newPc) |-> redirect);
endmodule

bind ftrap_top ftrap_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .faultValid(faultValid),
  .faultReady(faultReady),
  .redirect  (redirect),
  .newPc     (newPc)
);

// File: tb/ftrap_top_tb_top.sv
`timescale 1ns/1ps
module ftrap_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [3:0]  faultKind = '0;
  logic [63:0] faultPc = '0, faultVa = '0;
  logic [31:0] instrWord = '0;
  logic [2:0]  accFlags = '0;
  logic        reqPteLoad = 1'b0, reqPrefetch = 1'b0, reqMisspec = 1'b0, isTrap = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        faultReady, redirect;
  logic [63:0] newPc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ftrap_top dut_i (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultKind(faultKind),
    .faultPc(faultPc), .faultVa(faultVa), .instrWord(instrWord),
    .accFlags(accFlags), .reqPteLoad(reqPteLoad), .reqPrefetch(reqPrefetch),
    .reqMisspec(reqMisspec), .isTrap(isTrap), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .faultReady(faultReady), .redirect(redirect), .newPc(newPc)
  );

  // behavioural reference state, index = register address
  logic [63:0] mReg [16];
  logic        mRedirect;
  logic [63:0] mNewPc;

  function automatic logic [63:0] handlerOffset(int k);
    logic [63:0] offs [15] = '{64'h0001, 64'h0101, 64'h0401, 64'h0301, 64'h0201,
                               64'h0281, 64'h0381, 64'h0381, 64'h0181, 64'h0081,
                               64'h0481, 64'h0501, 64'h0501, 64'h0581, 64'h2001};
    return (k < 15) ? offs[k] : 64'h0;
  endfunction

  function automatic logic [63:0] pageForm(logic [63:0] base, logic [63:0] a);
    logic [63:0] pn;
    pn = (a >> 13) & ((64'h1 << 30) - 1);
    return base | (pn << 3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mReg[i] = '0;
      mRedirect = 1'b0;
      mNewPc    = '0;
    end else begin
      automatic bit take = faultValid && !mRedirect;
      automatic int k = int'(faultKind);
      automatic logic [63:0] oldH = mReg[6];
      automatic logic [63:0] oldD = mReg[7];
      automatic logic [63:0] oldI = mReg[8];
      if (take) begin
        automatic logic [63:0] e = mReg[0];
        mNewPc = oldH + handlerOffset(k);
        if (!(k == 11 || k == 12) || faultPc[1:0] == 2'b00) e = faultPc;
        if (isTrap) e = e + 64'd4;
        mReg[0] = e;
        if (k >= 3 && k <= 7 && !reqPteLoad && !reqPrefetch && !reqMisspec) begin
          mReg[1] = faultVa;
          mReg[2] = 64'(instrWord[31:26]) * 64'd2048 + 64'(instrWord[25:21]) * 64'd64
                  + 64'(accFlags[0]) + (k == 7 ? 64'd2 : 64'd0)
                  + 64'(accFlags[1]) * 64'd4 + 64'(accFlags[2]) * 64'd8
                  + (k == 5 ? 64'd16 : 64'd0);
          mReg[3] = pageForm(oldD, faultVa);
        end
        if ((k == 8 || k == 9) && !reqMisspec) begin
          mReg[5] = faultPc;
          mReg[4] = pageForm(oldI, faultPc);
        end
      end
      mRedirect = take;
      if (regWrEn && regAddr >= 4'd6 && regAddr <= 4'd8) mReg[regAddr] = regWrData;
    end
  end

  function automatic string regTag(logic [3:0] a);
    case (a)
      4'd0: return "R2/R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check64("R8", "redirect", 64'(redirect), 64'(mRedirect));
    check64("R9", "faultReady", 64'(faultReady), 64'(!mRedirect));
    check64("R1", "newPc", newPc, mNewPc);
    check64(regTag(regAddr), "readback", regRdData, (regAddr <= 4'd8) ? mReg[regAddr] : 64'h0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state through every address
    for (int a = 0; a < 16; a++) begin
      regAddr = 4'(a);
      @(negedge clk);
      check64("R11", "reset readback", regRdData, 64'h0);
      check64("R11", "reset redirect", 64'(redirect), 64'h0);
      check64("R11", "reset ready", 64'(faultReady), 64'h1);
      check64("R11", "reset newPc", newPc, 64'h0);
    end
    // R10: load bases, then try writes at read-only addresses
    for (int a = 0; a < 16; a++) begin
      regWrEn   = 1'b1;
      regAddr   = 4'(a);
      regWrData = {$urandom, $urandom} & 64'hFFF0_0000_0000_FFF8;
      @(negedge clk);
      regWrEn = 1'b0;
      compareAll();
    end
    // directed: every kind, trap and fault, qualifiers clear (R1..R7)
    for (int k = 0; k < 15; k++) begin
      for (int t = 0; t < 2; t++) begin
        faultValid = 1'b1; faultKind = 4'(k); isTrap = t[0];
        faultPc = {$urandom, $urandom}; faultVa = {$urandom, $urandom};
        instrWord = $urandom; accFlags = 3'($urandom);
        reqPteLoad = 1'b0; reqPrefetch = 1'b0; reqMisspec = 1'b0;
        regAddr = 4'(k % 9);
        @(negedge clk);
        faultValid = 1'b0;
        compareAll();
        for (int a = 0; a < 6; a++) begin
          regAddr = 4'(a);
          #0.5 check64(regTag(regAddr), "post-fault readback", regRdData, mReg[a]);
        end
        @(negedge clk);
        compareAll();
      end
    end
    // random traffic with back-to-back offers and base rewrites
    for (int n = 0; n < 4000; n++) begin
      faultValid  = ($urandom % 10) < 7;
      faultKind   = 4'($urandom % 15);
      isTrap      = $urandom % 2;
      faultPc     = {$urandom, $urandom};
      faultVa     = {$urandom, $urandom};
      instrWord   = $urandom;
      accFlags    = 3'($urandom);
      reqPteLoad  = ($urandom % 4) == 0;
      reqPrefetch = ($urandom % 4) == 0;
      reqMisspec  = ($urandom % 4) == 0;
      regAddr     = 4'($urandom % 16);
      regWrEn     = ($urandom % 8) == 0;
      regWrData   = {$urandom, $urandom};
      @(negedge clk);
      compareAll();
    end
    faultValid = 1'b0; regWrEn = 1'b0;
    @(negedge clk);
    compareAll();
    summary();
  end
endmodule